// File: doc/BRIEF.md
# Stereo Logarithmic Attenuator with Soft Mute

This block scales a stereo stream of signed audio samples by a gain selected with a 6-bit attenuation code. Each step of the code adds 1 dB of attenuation, starting from unity at code 0. The top code silences the stream completely. The gain is a fixed-point linear factor taken from a table that is computed when the design is built. That factor is multiplied into both channels, and each product is rounded and then clamped to the sample width.

A soft mute scales the table gain by a ramp level. While mute is held, the level falls by one step per input sample until it reaches zero. When mute is released, the level climbs back by one step per sample. The output therefore fades rather than jumping. A volume-enable input selects between the programmed code and a fixed 0 dB gain. With enable low, the block behaves as a plain unity-gain path, and the mute still works.

Samples arrive as a left/right pair with a one-cycle valid strobe. The scaled pair appears one clock later with its own strobe.

Top module: `vol_mute`

## Requirements
- R1: For code n from 0 to 61, the table gain is round(32768 * 10^(-n/20)), with unity equal to 32768. Code 62 uses the same gain as -61 dB.
- R2: Code 63 with volume enabled gives a gain of zero, so every output sample is 0.
- R3: While vol_en is low, vol_code is ignored and the table gain is unity (code 0), whatever the code value. Mute still applies.
- R4: Each channel output is floor((x * g_eff + 16384) / 32768), which is round-to-nearest with ties toward positive infinity. The result is then clamped to the signed range of the sample width.
- R5: out_valid is high exactly one clock after in_valid is high. Both output samples change only on those cycles. Both channels use the gain derived from vol_code, vol_en and the ramp level present in the cycle of the strobe.
- R6: The ramp level runs from 0 to L = 2^RAMP_W and is L after reset. The effective gain is floor(g * level / L). The level used for a sample is the value it held before that sample's step.
- R7: With mute high, every input strobe lowers the level by one until it reaches 0. From full level, the output is exactly silent from the (L+1)-th sample onward, and it stays silent while mute remains high.
- R8: With mute low, every input strobe raises the level by one until it reaches L. A code change during the ramp takes effect from the next strobe.
- R9: During reset, out_valid, out_left and out_right are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Strobe for one input sample pair |
| in_left | input | DATA_W | Left input sample, signed |
| in_right | input | DATA_W | Right input sample, signed |
| vol_code | input | 6 | Attenuation code, 1 dB per step, 63 means silence |
| vol_en | input | 1 | High: use vol_code; low: fixed 0 dB |
| mute | input | 1 | Soft mute request |
| out_valid | output | 1 | Strobe for one output sample pair |
| out_left | output | DATA_W | Scaled left sample, signed |
| out_right | output | DATA_W | Scaled right sample, signed |

## Verification
The assertions check the following on every cycle:
- the output strobe follows the input strobe by one cycle, and the outputs hold between strobes;
- the ramp level stays within bounds and moves by exactly one step per strobe in the direction that mute selects;
- code 63 and a zero level both force silence, and a zero input produces a zero output.

Only the bench's sweeps can show the following:
- the exact table values across all 64 codes;
- the rounding of each product;
- the full shape of a mute fade and the recovery from it;
- that vol_code has no effect while vol_en is low.

// File: rtl/vol_mute.sv
module vol_mute #(
  parameter int DATA_W = 20,
  parameter int FRAC   = 15,
  parameter int RAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_left,
  input  logic [DATA_W-1:0] in_right,
  input  logic [5:0]        vol_code,
  input  logic              vol_en,
  input  logic              mute,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_left,
  output logic [DATA_W-1:0] out_right
);
  localparam int GAIN_W = FRAC + 1;
  localparam int LVL_W  = RAMP_W + 1;
  localparam int GP_W   = GAIN_W + LVL_W;
  localparam int P_W    = DATA_W + GAIN_W + 2;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(1) << RAMP_W;
  localparam logic signed [P_W-1:0] HALF = P_W'(1) << (FRAC - 1);
  localparam logic signed [P_W-1:0] SMAX = P_W'((longint'(1) << (DATA_W - 1)) - 1);
  localparam logic signed [P_W-1:0] SMIN = -(P_W'(1) << (DATA_W - 1));

  logic [GAIN_W-1:0] gain_lut [64];

  for (genvar i = 0; i < 64; i++) begin : g_lut
    localparam int DB = (i == 62) ? 61 : i;
    localparam int GV = (i == 63) ? 0 :
      $rtoi(real'(longint'(1) << FRAC) * $pow(10.0, -real'(DB) / 20.0) + 0.5);
    assign gain_lut[i] = GAIN_W'(GV);
  end

  logic [LVL_W-1:0]  level;
  logic [5:0]        code_sel;
  logic [GAIN_W-1:0] g_tab;
  logic [GP_W-1:0]   g_prod;
  logic [GAIN_W:0]   g_eff;

  assign code_sel = vol_en ? vol_code : 6'd0;
  assign g_tab    = gain_lut[code_sel];
  assign g_prod   = GP_W'(g_tab) * GP_W'(level);
  assign g_eff    = g_prod[GP_W-1:RAMP_W];

  function automatic logic [DATA_W-1:0] scale(input logic [DATA_W-1:0] x,
                                              input logic [GAIN_W:0] g);
    logic signed [P_W-1:0] p, r;
    p = P_W'($signed(x)) * $signed({1'b0, g});
    r = (p + HALF) >>> FRAC;
    if (r > SMAX)      r = SMAX;
    else if (r < SMIN) r = SMIN;
    return r[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level     <= FULL;
      out_valid <= 1'b0;
      out_left  <= '0;
      out_right <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_left  <= scale(in_left, g_eff);
        out_right <= scale(in_right, g_eff);
        if (mute && level != '0)        level <= level - 1'b1;
        else if (!mute && level != FULL) level <= level + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vol_mute_chk.sv
module vol_mute_chk #(
  parameter int DATA_W = 20,
  parameter int RAMP_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_left,
  input logic [5:0]        vol_code,
  input logic              vol_en,
  input logic              mute,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_left,
  input logic [DATA_W-1:0] out_right,
  input logic [RAMP_W:0]   level
);
  localparam logic [RAMP_W:0] FULL = (RAMP_W + 1)'(1) << RAMP_W;

  // R5
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R5
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_left) && $stable(out_right));
  // R2
  hard_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && vol_en && vol_code == 6'd63 |=> out_left == '0 && out_right == '0);
  // R6
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= FULL);
  // R6
  zero_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && level == '0 |=> out_left == '0 && out_right == '0);
  // R7
  ramp_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mute && level != '0 |=> level == $past(level) - 1'b1);
  // R8
  ramp_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !mute && level != FULL |=> level == $past(level) + 1'b1);
  // R6
  level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(level));
  // R4
  zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_left == '0 |=> out_left == '0);
endmodule

bind vol_mute vol_mute_chk #(.DATA_W(DATA_W), .RAMP_W(RAMP_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
  .vol_code(vol_code), .vol_en(vol_en), .mute(mute), .out_valid(out_valid),
  .out_left(out_left), .out_right(out_right), .level(level)
);

// File: tb/vol_mute_tb.sv
module vol_mute_tb_top;
  localparam int DW = 20;
  localparam int RW = 3;
  localparam int L  = 1 << RW;

  logic clk = 0, rst_n = 0, in_valid = 0, vol_en = 1, mute = 0;
  logic [DW-1:0] in_left = '0, in_right = '0;
  logic [5:0] vol_code = '0;
  logic out_valid;
  logic [DW-1:0] out_left, out_right;

  int total = 0, bad = 0, lvl = L;
  bit done = 0;

  always #5 clk = ~clk;

  vol_mute #(.DATA_W(DW), .FRAC(15), .RAMP_W(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_left(in_left),
    .in_right(in_right), .vol_code(vol_code), .vol_en(vol_en), .mute(mute),
    .out_valid(out_valid), .out_left(out_left), .out_right(out_right));

  function automatic longint gain_of(int code);
    int n;
    if (code == 63) return 0;
    n = (code == 62) ? 61 : code;
    return longint'($floor(32768.0 * $pow(10.0, -real'(n) / 20.0) + 0.5));
  endfunction

  function automatic longint expect_out(longint x, int code, bit en, int lv);
    longint g, r;
    g = gain_of(en ? code : 0);
    g = (g * lv) >> RW;
    r = (x * g + 16384) >>> 15;
    if (r > 524287) r = 524287;
    if (r < -524288) r = -524288;
    return r;
  endfunction

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(string req, longint xl, longint xr);
    longint el, er;
    @(negedge clk);
    in_left = DW'(xl); in_right = DW'(xr); in_valid = 1;
    el = expect_out(xl, vol_code, vol_en, lvl);
    er = expect_out(xr, vol_code, vol_en, lvl);
    @(negedge clk);
    in_valid = 0;
    check({req, " R5 strobe"}, out_valid, 1);
    check({req, " left"}, longint'($signed(out_left)), el);
    check({req, " right"}, longint'($signed(out_right)), er);
    if (mute && lvl > 0) lvl--;
    else if (!mute && lvl < L) lvl++;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint vals[6] = '{524287, -524288, 1, -1, 123457, -300001};
    repeat (3) @(negedge clk);
    // R9
    check("R9 out_valid", out_valid, 0);
    check("R9 out_left", out_left, 0);
    check("R9 out_right", out_right, 0);
    rst_n = 1;

    // R1 R2 R4: all codes, several sample values
    for (int c = 0; c < 64; c++) begin
      vol_code = 6'(c);
      for (int k = 0; k < 6; k++)
        send(c == 63 ? "R2" : "R1 R4", vals[k], vals[5 - k]);
    end
    // R4 rounding ties and small values
    vol_code = 6'd6;
    for (int x = -40; x <= 40; x++) send("R4 rounding", x, -x);

    // R5 hold between strobes
    vol_code = 6'd3;
    send("R5", 200000, -7);
    begin
      logic [DW-1:0] hl, hr;
      hl = out_left; hr = out_right;
      vol_code = 6'd40; in_left = 20'd5;
      repeat (3) @(negedge clk);
      check("R5 idle valid", out_valid, 0);
      check("R5 hold left", out_left, hl);
      check("R5 hold right", out_right, hr);
    end

    // R3 code ignored when disabled
    vol_en = 0;
    for (int c = 0; c < 64; c += 7) begin
      vol_code = 6'(c);
      send("R3", 345678, -345678);
    end

    // R7 fade down under disabled volume, then held silence
    mute = 1;
    for (int s = 0; s < L + 4; s++) send("R7 R6", 400000, -400000);
    check("R7 silent", out_left, 0);
    // R8 ramp up with code change mid-ramp
    vol_en = 1; vol_code = 6'd2;
    mute = 0;
    for (int s = 0; s < L + 3; s++) begin
      if (s == 3) vol_code = 6'd10;
      send("R8 R6", 400000, -250000);
    end
    // R7 partial mute, then release
    mute = 1;
    for (int s = 0; s < 3; s++) send("R7", -500000, 500000);
    mute = 0;
    for (int s = 0; s < 5; s++) send("R8", -500000, 500000);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule